// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a NOR-style flash controller and watches the host's bus write cycles. It recognises the multi-write unlock and command sequences and tracks the operating mode: plain read, autoselect, unlock bypass or erase-suspend read. It also keeps a separate flag that shows whether the secure region is mapped in. When a sequence completes, the block raises exactly one bit of a command strobe vector for one clock cycle. The address and data of the write that completed the sequence are latched alongside the strobe.

The controller feeds the block two inputs. A busy flag marks an embedded operation in flight. A sector-erase-active flag marks that the running operation is a sector erase and can be suspended. The block has no array, no operation timing and no status reporting. Each write is sampled on a rising clock edge while `wr_en` is high. The resulting strobe, latched address and data, and updated mode all appear in the next cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` reads 0 (read), `secure_sel` is 0 and every `cmd_strobe` bit is 0.
- R2: Unlock and command writes are matched on address bits 10..0 and data bits 7..0 only. The first unlock write is data AAh at address 555h and the second is 55h at 2AAh; all higher address and data bits are don't-care.
- R3: After the two unlock writes, a write to 555h selects the command. 90h raises strobe bit 7 and sets `mode` to 1 (autoselect). 88h raises bit 8 and sets `secure_sel`. A0h arms a program, and the next write raises bit 0 with that write's address and data.
- R4: 80h at 555h after the unlock writes, then a second unlock pair, completes an erase. 10h at 555h raises bit 1 (chip erase). 30h at any address raises bit 2 (sector erase), with `cmd_sector` equal to address bits 21..15. Erase setup and bypass entry are refused while an erase is suspended.
- R5: 20h at 555h after the unlock writes sets `mode` to 2 (bypass). In bypass, A0h at any address followed by one more write raises bit 0. 90h followed by a data byte of 00h returns `mode` to 0; 90h followed by any other byte leaves `mode` at 2.
- R6: With no sequence in progress and `mode` not 2, F0h at any address raises bit 5 and clears autoselect. The resulting `mode` is 3 if an erase is suspended and 0 otherwise.
- R7: B0h at any address while `sect_erase_active` is high and no erase is suspended raises bit 3 and suspends. This holds in any sequence state and even while `busy` is high. From read mode, `mode` then reads 3.
- R8: 30h with no sequence in progress raises bit 4 and returns `mode` from 3 to 0, but only while `mode` is 3. In any other mode it has no effect.
- R9: 98h at address 055h with no sequence in progress raises bit 6 only while `mode` is 0 or 1. In modes 2 and 3 it has no effect.
- R10: While `secure_sel` is 1, the autoselect command (unlock pair, 90h at 555h) followed by a 00h write raises bit 9, clears `secure_sel` and sets `mode` to 0.
- R11: A write that does not match the expected next step drops the partial sequence with no strobe and no mode change. Decoding then restarts from the current mode.
- R12: While `busy` is high, every write except an accepted suspend is ignored: no strobe, no mode change and no sequence progress.
- R13: At most one strobe bit is high in any cycle. A strobe is high only in the cycle after the write that caused it, and `cmd_addr`/`cmd_data` hold that write's full address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | AW (22) | Write address |
| wr_data | input | DW (16) | Write data |
| busy | input | 1 | Embedded operation in progress |
| sect_erase_active | input | 1 | Running operation is a suspendable sector erase |
| cmd_strobe | output | 10 | One-cycle command strobes, bit map per R3..R10 |
| cmd_addr | output | AW (22) | Address of the write that completed the command |
| cmd_data | output | DW (16) | Data of the write that completed the command |
| cmd_sector | output | AW-SECT_LSB (7) | Sector field of `cmd_addr` |
| mode | output | 2 | 0 read, 1 autoselect, 2 bypass, 3 erase-suspend read |
| secure_sel | output | 1 | Secure region mapped in |

## Verification
The bench puts full-width unlock writes with high address and data bits set against a decoder that compared too many bits; such a decoder would never reach autoselect. It breaks sequences partway through and then sends the byte that would have completed them. A decoder that kept partial state would then emit a stray program or erase. Suspend is driven while `busy` is high, and resume, CFI and reset are driven in every mode. A wrong mode gate shows up either as a missing strobe or as an erase-suspend state that reset clears when it should not. Secure-region exit is exercised both ways: after autoselect entry a decoder that skipped the 00h step would leave `secure_sel` set, and one that treated every autoselect as an exit would clear it too early.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   localparam int NUM_CMDS = 10;

   typedef enum logic [3:0] {
      CMD_PROGRAM    = 4'd0,
      CMD_CHIP_ERASE = 4'd1,
      CMD_SECT_ERASE = 4'd2,
      CMD_SUSPEND    = 4'd3,
      CMD_RESUME     = 4'd4,
      CMD_RESET      = 4'd5,
      CMD_CFI        = 4'd6,
      CMD_AUTOSEL    = 4'd7,
      CMD_SEC_ENTER  = 4'd8,
      CMD_SEC_EXIT   = 4'd9
   } cmd_e;

   typedef enum logic [1:0] {
      MODE_READ    = 2'd0,
      MODE_AUTOSEL = 2'd1,
      MODE_BYPASS  = 2'd2,
      MODE_ESUSP   = 2'd3
   } mode_e;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3,
      SQ_BPGM, SQ_BRST, SQ_SEXIT
   } seq_e;

   localparam logic [7:0] B_UNL1   = 8'hAA;
   localparam logic [7:0] B_UNL2   = 8'h55;
   localparam logic [7:0] B_AUTO   = 8'h90;
   localparam logic [7:0] B_SECEN  = 8'h88;
   localparam logic [7:0] B_PGM    = 8'hA0;
   localparam logic [7:0] B_ERSET  = 8'h80;
   localparam logic [7:0] B_BYP    = 8'h20;
   localparam logic [7:0] B_CHIP   = 8'h10;
   localparam logic [7:0] B_SECT   = 8'h30;
   localparam logic [7:0] B_SUSP   = 8'hB0;
   localparam logic [7:0] B_RST    = 8'hF0;
   localparam logic [7:0] B_QUERY  = 8'h98;
   localparam logic [7:0] B_ZERO   = 8'h00;

endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
   parameter int KEY_BITS = 11
) (
   input  logic [KEY_BITS-1:0] key_addr,
   input  logic [7:0]          key_data,
   output logic                hit_unl1,
   output logic                hit_unl2,
   output logic                hit_query,
   output logic [7:0]          dbyte
);
   localparam logic [KEY_BITS-1:0] K_UNL1  = KEY_BITS'(11'h555);
   localparam logic [KEY_BITS-1:0] K_UNL2  = KEY_BITS'(11'h2AA);
   localparam logic [KEY_BITS-1:0] K_QUERY = KEY_BITS'(11'h055);

   generate
      if (KEY_BITS < 11) begin : g_bad_key
         $error("fcd_match: KEY_BITS must be at least 11");
      end
   endgenerate

   assign hit_unl1  = (key_addr == K_UNL1);
   assign hit_unl2  = (key_addr == K_UNL2);
   assign hit_query = (key_addr == K_QUERY);
   assign dbyte     = key_data;

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
   import fcd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  logic  busy,
   input  logic  sect_erase_active,
   input  logic  hit_unl1,
   input  logic  hit_unl2,
   input  logic  hit_query,
   input  logic [7:0] dbyte,
   input  mode_e base,
   input  mode_e mode,
   input  logic  susp,
   input  logic  sec,
   output logic  ev_valid,
   output cmd_e  ev_code,
   output logic  base_we,
   output mode_e base_nx,
   output logic  susp_set,
   output logic  susp_clr,
   output logic  sec_set,
   output logic  sec_clr
);
   seq_e seq_q, seq_nx;

   always_comb begin
      seq_nx   = seq_q;
      ev_valid = 1'b0;
      ev_code  = CMD_PROGRAM;
      base_we  = 1'b0;
      base_nx  = base;
      susp_set = 1'b0;
      susp_clr = 1'b0;
      sec_set  = 1'b0;
      sec_clr  = 1'b0;
      if (wr_en) begin
         if (dbyte == B_SUSP && sect_erase_active && !susp) begin
            ev_valid = 1'b1;
            ev_code  = CMD_SUSPEND;
            susp_set = 1'b1;
            seq_nx   = SQ_IDLE;
         end else if (!busy) begin
            seq_nx = SQ_IDLE;
            case (seq_q)
               SQ_IDLE: begin
                  if (base == MODE_BYPASS) begin
                     if (dbyte == B_PGM)       seq_nx = SQ_BPGM;
                     else if (dbyte == B_AUTO) seq_nx = SQ_BRST;
                  end else if (dbyte == B_SECT && mode == MODE_ESUSP) begin
                     ev_valid = 1'b1;
                     ev_code  = CMD_RESUME;
                     susp_clr = 1'b1;
                  end else if (dbyte == B_RST) begin
                     ev_valid = 1'b1;
                     ev_code  = CMD_RESET;
                     base_we  = 1'b1;
                     base_nx  = MODE_READ;
                  end else if (dbyte == B_QUERY && hit_query &&
                               (mode == MODE_READ || mode == MODE_AUTOSEL)) begin
                     ev_valid = 1'b1;
                     ev_code  = CMD_CFI;
                  end else if (dbyte == B_UNL1 && hit_unl1) begin
                     seq_nx = SQ_U1;
                  end
               end
               SQ_U1: if (dbyte == B_UNL2 && hit_unl2) seq_nx = SQ_U2;
               SQ_U2: begin
                  if (hit_unl1) begin
                     case (dbyte)
                        B_AUTO: begin
                           ev_valid = 1'b1;
                           ev_code  = CMD_AUTOSEL;
                           base_we  = 1'b1;
                           base_nx  = MODE_AUTOSEL;
                           seq_nx   = sec ? SQ_SEXIT : SQ_IDLE;
                        end
                        B_SECEN: begin
                           ev_valid = 1'b1;
                           ev_code  = CMD_SEC_ENTER;
                           sec_set  = 1'b1;
                        end
                        B_PGM:   seq_nx = SQ_PGM;
                        B_ERSET: if (!susp) seq_nx = SQ_E1;
                        B_BYP: begin
                           if (!susp) begin
                              base_we = 1'b1;
                              base_nx = MODE_BYPASS;
                           end
                        end
                        default: seq_nx = SQ_IDLE;
                     endcase
                  end
               end
               SQ_PGM, SQ_BPGM: begin
                  ev_valid = 1'b1;
                  ev_code  = CMD_PROGRAM;
               end
               SQ_E1: if (dbyte == B_UNL1 && hit_unl1) seq_nx = SQ_E2;
               SQ_E2: if (dbyte == B_UNL2 && hit_unl2) seq_nx = SQ_E3;
               SQ_E3: begin
                  if (dbyte == B_CHIP && hit_unl1) begin
                     ev_valid = 1'b1;
                     ev_code  = CMD_CHIP_ERASE;
                  end else if (dbyte == B_SECT) begin
                     ev_valid = 1'b1;
                     ev_code  = CMD_SECT_ERASE;
                  end
               end
               SQ_BRST: begin
                  if (dbyte == B_ZERO) begin
                     base_we = 1'b1;
                     base_nx = MODE_READ;
                  end
               end
               SQ_SEXIT: begin
                  if (dbyte == B_ZERO) begin
                     ev_valid = 1'b1;
                     ev_code  = CMD_SEC_EXIT;
                     sec_clr  = 1'b1;
                     base_we  = 1'b1;
                     base_nx  = MODE_READ;
                  end
               end
               default: seq_nx = SQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) seq_q <= SQ_IDLE;
      else        seq_q <= seq_nx;
   end

   // R4
   erase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_q == SQ_E3 && $past(seq_q) != SQ_E3) |-> $past(seq_q) == SQ_E2);

   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !$past(ev_valid)) |-> $stable(seq_q));

endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
   import fcd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  base_we,
   input  mode_e base_nx,
   input  logic  susp_set,
   input  logic  susp_clr,
   input  logic  sec_set,
   input  logic  sec_clr,
   output mode_e base,
   output logic  susp,
   output logic  sec,
   output mode_e mode
);
   mode_e base_q;
   logic  susp_q, sec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= MODE_READ;
         susp_q <= 1'b0;
         sec_q  <= 1'b0;
      end else begin
         if (base_we)       base_q <= base_nx;
         if (susp_set)      susp_q <= 1'b1;
         else if (susp_clr) susp_q <= 1'b0;
         if (sec_set)       sec_q  <= 1'b1;
         else if (sec_clr)  sec_q  <= 1'b0;
      end
   end

   assign base = base_q;
   assign susp = susp_q;
   assign sec  = sec_q;
   assign mode = (susp_q && base_q == MODE_READ) ? MODE_ESUSP : base_q;

   // R6
   base_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_q != MODE_ESUSP);

   // R10
   sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sec_q) |-> base_q == MODE_READ);

endmodule

// File: rtl/fcd_out.sv
module fcd_out
   import fcd_pkg::*;
#(
   parameter int AW   = 22,
   parameter int DW   = 16,
   parameter int NCMD = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_valid,
   input  cmd_e          ev_code,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic [NCMD-1:0] cmd_strobe,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data
);
   logic valid_q;
   cmd_e code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         code_q   <= CMD_PROGRAM;
         cmd_addr <= '0;
         cmd_data <= '0;
      end else begin
         valid_q <= ev_valid;
         if (ev_valid) begin
            code_q   <= ev_code;
            cmd_addr <= addr;
            cmd_data <= data;
         end
      end
   end

   generate
      for (genvar i = 0; i < NCMD; i++) begin : g_strobe
         assign cmd_strobe[i] = valid_q && (int'(code_q) == i);
      end
   endgenerate

   // R13
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_strobe));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int AW       = 22,
   parameter int DW       = 16,
   parameter int SECT_LSB = 15,
   parameter int KEY_BITS = 11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [DW-1:0]          wr_data,
   input  logic                   busy,
   input  logic                   sect_erase_active,
   output logic [NUM_CMDS-1:0]    cmd_strobe,
   output logic [AW-1:0]          cmd_addr,
   output logic [DW-1:0]          cmd_data,
   output logic [AW-SECT_LSB-1:0] cmd_sector,
   output logic [1:0]             mode,
   output logic                   secure_sel
);
   localparam logic [NUM_CMDS-1:0] SUSP_MASK = NUM_CMDS'(1) << int'(CMD_SUSPEND);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("flash_cmd_decoder: DW must be at least 8");
      end
      if (SECT_LSB >= AW || SECT_LSB < 1) begin : g_bad_sect
         $error("flash_cmd_decoder: SECT_LSB out of range");
      end
      if (KEY_BITS > AW) begin : g_bad_key
         $error("flash_cmd_decoder: KEY_BITS exceeds AW");
      end
   endgenerate

   logic       hit_unl1, hit_unl2, hit_query;
   logic [7:0] dbyte;
   logic       ev_valid, base_we, susp_set, susp_clr, sec_set, sec_clr;
   logic       susp, sec;
   cmd_e       ev_code;
   mode_e      base, base_nx, mode_w;

   fcd_match #(.KEY_BITS(KEY_BITS)) i_match (
      .key_addr (wr_addr[KEY_BITS-1:0]),
      .key_data (wr_data[7:0]),
      .hit_unl1 (hit_unl1),
      .hit_unl2 (hit_unl2),
      .hit_query(hit_query),
      .dbyte    (dbyte)
   );

   fcd_seq i_seq (
      .clk              (clk),
      .rst_n            (rst_n),
      .wr_en            (wr_en),
      .busy             (busy),
      .sect_erase_active(sect_erase_active),
      .hit_unl1         (hit_unl1),
      .hit_unl2         (hit_unl2),
      .hit_query        (hit_query),
      .dbyte            (dbyte),
      .base             (base),
      .mode             (mode_w),
      .susp             (susp),
      .sec              (sec),
      .ev_valid         (ev_valid),
      .ev_code          (ev_code),
      .base_we          (base_we),
      .base_nx          (base_nx),
      .susp_set         (susp_set),
      .susp_clr         (susp_clr),
      .sec_set          (sec_set),
      .sec_clr          (sec_clr)
   );

   fcd_mode i_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_we (base_we),
      .base_nx (base_nx),
      .susp_set(susp_set),
      .susp_clr(susp_clr),
      .sec_set (sec_set),
      .sec_clr (sec_clr),
      .base    (base),
      .susp    (susp),
      .sec     (sec),
      .mode    (mode_w)
   );

   fcd_out #(.AW(AW), .DW(DW), .NCMD(NUM_CMDS)) i_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .ev_code   (ev_code),
      .addr      (wr_addr),
      .data      (wr_data),
      .cmd_strobe(cmd_strobe),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data)
   );

   assign cmd_sector = cmd_addr[AW-1:SECT_LSB];
   assign mode       = mode_w;
   assign secure_sel = sec;

   // R13
   strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmd_strobe) |-> $past(wr_en));

   // R12
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(cmd_strobe & ~SUSP_MASK)) |-> !$past(busy));

   // R12
   busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !$stable(mode)) |-> cmd_strobe[int'(CMD_SUSPEND)]);

   // R7
   suspend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe[int'(CMD_SUSPEND)] |-> $past(sect_erase_active));

   // R8
   resume_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe[int'(CMD_RESUME)] |-> ($past(mode) == 2'd3 && mode == 2'd0));

   // R9
   cfi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe[int'(CMD_CFI)] |-> ($past(mode) == 2'd0 || $past(mode) == 2'd1));

   // R11
   mode_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |-> $past(wr_en));

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [21:0] wr_addr;
   logic [15:0] wr_data;
   logic        busy;
   logic        sea;
   logic [9:0]  cmd_strobe;
   logic [21:0] cmd_addr;
   logic [15:0] cmd_data;
   logic [6:0]  cmd_sector;
   logic [1:0]  mode;
   logic        secure_sel;

   int checks = 0;
   int fails  = 0;

   int          m_seq;
   int          m_base;
   bit          m_susp, m_sec;
   int          e_code;
   logic [21:0] e_addr;
   logic [15:0] e_data;

   always #2.5 clk = ~clk;

   flash_cmd_decoder i_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .sect_erase_active(sea),
      .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .cmd_sector(cmd_sector), .mode(mode), .secure_sel(secure_sel)
   );

   function automatic int exp_mode();
      return (m_susp && m_base == 0) ? 3 : m_base;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [21:0] a, input logic [15:0] d,
                        input bit b, input bit s);
      bit h1 = (a[10:0] == 11'h555);
      bit h2 = (a[10:0] == 11'h2AA);
      bit hq = (a[10:0] == 11'h055);
      logic [7:0] db = d[7:0];
      int md = exp_mode();
      int nx;
      e_code = -1;
      if (db == 8'hB0 && s && !m_susp) begin
         e_code = 3; m_susp = 1; m_seq = 0;
      end else if (!b) begin
         nx = 0;
         case (m_seq)
            0: begin
               if (m_base == 2) begin
                  if (db == 8'hA0) nx = 7;
                  else if (db == 8'h90) nx = 8;
               end else if (db == 8'h30 && md == 3) begin
                  e_code = 4; m_susp = 0;
               end else if (db == 8'hF0) begin
                  e_code = 5; m_base = 0;
               end else if (db == 8'h98 && hq && (md == 0 || md == 1)) begin
                  e_code = 6;
               end else if (db == 8'hAA && h1) nx = 1;
            end
            1: if (db == 8'h55 && h2) nx = 2;
            2: if (h1) begin
                  case (db)
                     8'h90: begin e_code = 7; m_base = 1; nx = m_sec ? 9 : 0; end
                     8'h88: begin e_code = 8; m_sec = 1; end
                     8'hA0: nx = 3;
                     8'h80: if (!m_susp) nx = 4;
                     8'h20: if (!m_susp) m_base = 2;
                     default: nx = 0;
                  endcase
               end
            3, 7: e_code = 0;
            4: if (db == 8'hAA && h1) nx = 5;
            5: if (db == 8'h55 && h2) nx = 6;
            6: begin
               if (db == 8'h10 && h1) e_code = 1;
               else if (db == 8'h30) e_code = 2;
            end
            8: if (db == 8'h00) m_base = 0;
            9: if (db == 8'h00) begin e_code = 9; m_sec = 0; m_base = 0; end
            default: nx = 0;
         endcase
         m_seq = nx;
      end
      if (e_code >= 0) begin
         e_addr = a; e_data = d;
      end
   endtask

   task automatic check_out(input string req);
      logic [9:0] es = (e_code >= 0) ? (10'd1 << e_code) : 10'd0;
      chk(cmd_strobe == es, req, "strobe", 32'(cmd_strobe), 32'(es));
      chk(mode == 2'(exp_mode()), req, "mode", 32'(mode), 32'(exp_mode()));
      chk(secure_sel == m_sec, req, "secure", 32'(secure_sel), 32'(m_sec));
      if (e_code >= 0) begin
         chk(cmd_addr == e_addr, req, "addr", 32'(cmd_addr), 32'(e_addr));
         chk(cmd_data == e_data, req, "data", 32'(cmd_data), 32'(e_data));
         chk(cmd_sector == e_addr[21:15], req, "sector", 32'(cmd_sector), 32'(e_addr[21:15]));
      end
   endtask

   task automatic wr(input logic [21:0] a, input logic [15:0] d,
                     input bit b, input bit s, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b; sea = s;
      model(a, d, b, s);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      check_out(req);
   endtask

   task automatic idle(input string req);
      @(negedge clk);
      wr_en = 1'b0;
      e_code = -1;
      @(posedge clk);
      #1;
      check_out(req);
   endtask

   task automatic unlock(input string req);
      wr(22'h000555, 16'h00AA, 0, 0, req);
      wr(22'h0002AA, 16'h0055, 0, 0, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic [7:0] cb[6]   = '{8'h90, 8'h88, 8'hA0, 8'h80, 8'h20, 8'h10};
      logic [7:0] sb[6]   = '{8'h30, 8'hB0, 8'hF0, 8'h00, 8'hA0, 8'h90};
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0; sea = 1'b0;
      m_seq = 0; m_base = 0; m_susp = 0; m_sec = 0; e_code = -1;
      seed = $urandom(32'd2024);
      repeat (4) @(posedge clk);
      #1;
      chk(cmd_strobe == 10'd0 && mode == 2'd0 && secure_sel == 1'b0, "R1", "reset",
          {19'd0, cmd_strobe, mode, secure_sel}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      idle("R1");

      // R2: high address and data bits set on unlock/command writes
      wr(22'h3FF555, 16'hC3AA, 0, 0, "R2");
      wr(22'h2A82AA, 16'h7755, 0, 0, "R2");
      wr(22'h155555, 16'hFF90, 0, 0, "R2");
      wr(22'h000123, 16'h00F0, 0, 0, "R6");
      wr(22'h000055, 16'h0098, 0, 0, "R9");
      // R3 program
      unlock("R3"); wr(22'h000555, 16'h00A0, 0, 0, "R3");
      wr(22'h123456, 16'hBEEF, 0, 0, "R3");
      idle("R13");
      // R4 erases
      unlock("R4"); wr(22'h000555, 16'h0080, 0, 0, "R4"); unlock("R4");
      wr(22'h000555, 16'h0010, 0, 0, "R4");
      unlock("R4"); wr(22'h000555, 16'h0080, 0, 0, "R4"); unlock("R4");
      wr(22'h2A8123, 16'h0030, 0, 0, "R4");
      // R11 broken sequence
      wr(22'h000555, 16'h00AA, 0, 0, "R11");
      wr(22'h0002AB, 16'h0055, 0, 0, "R11");
      wr(22'h000555, 16'h00A0, 0, 0, "R11");
      wr(22'h000777, 16'h1234, 0, 0, "R11");
      unlock("R11"); wr(22'h000555, 16'h0077, 0, 0, "R11");
      // R5 bypass
      unlock("R5"); wr(22'h000555, 16'h0020, 0, 0, "R5");
      wr(22'h0ABCDE, 16'h00A0, 0, 0, "R5");
      wr(22'h3C0001, 16'h5A5A, 0, 0, "R5");
      wr(22'h000098, 16'h0055, 0, 0, "R9");
      wr(22'h000000, 16'h0090, 0, 0, "R5");
      wr(22'h000000, 16'h0011, 0, 0, "R5");
      wr(22'h000000, 16'h0090, 0, 0, "R5");
      wr(22'h000000, 16'h0000, 0, 0, "R5");
      // R7 suspend while busy, R12 busy ignore
      wr(22'h000000, 16'h00B0, 1, 1, "R7");
      unlock("R12");
      wr(22'h000555, 16'h00AA, 1, 0, "R12");
      wr(22'h0002AA, 16'h0055, 1, 0, "R12");
      wr(22'h000555, 16'h0090, 1, 0, "R12");
      wr(22'h000555, 16'h00A0, 0, 0, "R12");
      wr(22'h000055, 16'h0098, 0, 0, "R9");
      wr(22'h000000, 16'h00F0, 0, 0, "R6");
      unlock("R6"); wr(22'h000555, 16'h0090, 0, 0, "R6");
      wr(22'h000000, 16'h00F0, 0, 0, "R6");
      unlock("R4"); wr(22'h000555, 16'h0080, 0, 0, "R4");
      wr(22'h000555, 16'h00AA, 0, 0, "R4");
      wr(22'h000000, 16'h0030, 0, 0, "R8");
      wr(22'h000000, 16'h0030, 0, 0, "R8");
      // R10 secure region
      unlock("R3"); wr(22'h000555, 16'h0088, 0, 0, "R3");
      unlock("R10"); wr(22'h000555, 16'h0090, 0, 0, "R10");
      wr(22'h000000, 16'h0001, 0, 0, "R10");
      unlock("R10"); wr(22'h000555, 16'h0090, 0, 0, "R10");
      wr(22'h012345, 16'h0000, 0, 0, "R10");
      idle("R13");

      for (int i = 0; i < 4000; i++) begin
         int r = $urandom_range(0, 9);
         bit b = ($urandom_range(0, 15) == 0);
         bit s = ($urandom_range(0, 7) == 0);
         logic [21:0] hi = 22'($urandom) & 22'h3FF800;
         logic [15:0] dh = 16'($urandom) & 16'hFF00;
         case (r)
            0, 1, 2: wr(hi | 22'h555, dh | 16'hAA, b, s, "R13");
            3, 4:    wr(hi | 22'h2AA, dh | 16'h55, b, s, "R13");
            5:       wr(hi | 22'h555, dh | 16'(cb[$urandom_range(0, 5)]), b, s, "R13");
            6:       wr(22'($urandom), dh | 16'(sb[$urandom_range(0, 5)]), b, s, "R13");
            7:       wr(hi | 22'h055, dh | 16'h98, b, s, "R13");
            8:       wr(22'($urandom), 16'($urandom), b, s, "R13");
            default: idle("R13");
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule